// File: doc/BRIEF.md
# Parallel LCD Bus Transfer Sequencer

This block turns a one-byte command (write or read, with a register-select flag) into a complete bus cycle on a character-display style parallel bus. One engine serves two bus families: a split-strobe family, with separate read and write strobes, and an enable family, with one enable strobe plus a read/write level. The data path can be a full byte or a four-bit path on the upper four data lines, where each byte moves as two nibbles in a configurable order.

Before a data transfer the sequencer can read the display's status register and repeat that read until a chosen status bit shows ready. The bit index, the ready level and the register-select level used for status are all set by configuration inputs. Each access has three phases: address setup, strobe active and hold. Each phase lasts a configurable number of clocks. A one-cycle done pulse ends the command, and read data is valid in that cycle. The data pins' output enable is a separate output, so the tristate buffers can sit at the pad ring.

Top module: `lcd_par_seq`

## Requirements
- R1: With cfgMode6800=1, lcdEr is the enable strobe, active only in the strobe phase, and lcdRw is 1 for reads and 0 for writes throughout an access (1 when idle). With cfgMode6800=0, lcdEr is the read strobe, active low, during the strobe phase of reads only. lcdRw is the write strobe, low only during the strobe phase of writes. Read and write strobes are never active together.
- R2: With cfgNibble=0 a command makes one data access that drives or samples all of lcdDout/lcdDin. With cfgNibble=1 it makes two data accesses that use bits 7:4 only, and lcdDout[3:0] stays 0.
- R3: In nibble mode, cfgHighFirst=1 sends cmdWdata[7:4] first and places the first sampled nibble in cmdRdata[7:4]. cfgHighFirst=0 puts the low nibble first. The bit has no effect on 8-bit transfers.
- R4: lcdCs is active during every phase of every access, and only then. It is active high when cfgCsLow=0 and active low when cfgCsLow=1. The strobe is active only while lcdCs is active.
- R5: cfgStrobeInv=1 inverts lcdEr in both bus families.
- R6: With cfgBusyEn=1, every command starts with status-read accesses, repeated until the status bit reads ready. Only then does the data access begin.
- R7: The ready test uses lcdDin[cfgBusyIdx]. Ready is level 1 when cfgBusyLow=0 and level 0 when cfgBusyLow=1.
- R8: Status accesses drive lcdRs to cfgStatusRsHigh. Data accesses drive the opposite level when cfgBusyEn=1, or the latched cmdRs when cfgBusyEn=0. lcdRs is 0 when idle.
- R9: The setup, strobe and hold phases last cfgSetup, cfgPulse and cfgHold clocks respectively. A value of 0 counts as 1.
- R10: cmdDone is high for exactly one clock, in the cycle after the last hold cycle of the command. cmdRdata holds the read byte in that cycle. Status reads are sampled in the last strobe cycle.
- R11: lcdOe is high only during the phases of data write accesses. It is low during status reads, data reads and idle.
- R12: cmdStart is acted on only when the sequencer is idle. A start during a transfer changes neither the pins nor the number of done pulses.
- R13: After reset the bus is idle: chip select inactive, strobes inactive, lcdOe=0, cmdDone=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgMode6800 | input | 1 | 0 split read/write strobes, 1 enable plus read/write level |
| cfgNibble | input | 1 | 1 selects four-bit path on bits 7:4 |
| cfgHighFirst | input | 1 | Nibble order, 1 sends upper nibble first |
| cfgCsLow | input | 1 | 1 makes chip select active low |
| cfgStrobeInv | input | 1 | Inverts lcdEr |
| cfgBusyEn | input | 1 | Enables status polling before data |
| cfgBusyLow | input | 1 | 1 waits for the status bit to read 0 |
| cfgBusyIdx | input | 3 | Index of the status bit on lcdDin |
| cfgStatusRsHigh | input | 1 | Register-select level for status reads |
| cfgSetup | input | PHASE_W | Setup phase clocks |
| cfgPulse | input | PHASE_W | Strobe phase clocks |
| cfgHold | input | PHASE_W | Hold phase clocks |
| cmdStart | input | 1 | Starts a command when idle |
| cmdRead | input | 1 | 1 read, 0 write |
| cmdRs | input | 1 | Register-select level for the data access |
| cmdWdata | input | 8 | Write byte |
| cmdDone | output | 1 | One-cycle completion pulse |
| cmdRdata | output | 8 | Read byte |
| lcdDout | output | 8 | Data bus output value |
| lcdDin | input | 8 | Data bus input value |
| lcdOe | output | 1 | Data bus output enable |
| lcdRs | output | 1 | Register-select pin |
| lcdCs | output | 1 | Chip-select pin |
| lcdEr | output | 1 | Enable or read strobe pin |
| lcdRw | output | 1 | Read/write level or write strobe pin |

## Verification
The hardest case to reach is a status poll that fails several times and then succeeds, combined with a four-bit read. A wrong loop-back there would skip the poll, repeat a data nibble or lose the nibble order. The bench models the display behaviourally. It answers "not ready" on the status bit for a set number of status reads, then "ready", and returns a different byte on each data nibble. Another start pulse arrives in the middle of each such command. The pins are compared with the model on every clock. The number of status strobes seen at the pins is also counted.

// File: rtl/lcdseq_pkg.sv
package lcdseq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD} phase_t;

  // strobes from the control sequencer to the datapath
  typedef struct packed {
    logic active;     // an access is in progress
    logic isStatus;   // current access is a status read
    logic isRead;     // current access reads the bus
    logic strobeOn;   // strobe phase
    logic sampleNow;  // last strobe cycle: capture input
    logic nibSel;     // 0 first nibble, 1 second nibble
    logic loadCmd;    // latch command fields
  } busCtl_t;
endpackage

// File: rtl/lcdseq_ctrl.sv
module lcdseq_ctrl
  import lcdseq_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdStart,
  input  logic               cmdRead,
  input  logic               cfgBusyEn,
  input  logic               cfgNibble,
  input  logic [PHASE_W-1:0] cfgSetup,
  input  logic [PHASE_W-1:0] cfgPulse,
  input  logic [PHASE_W-1:0] cfgHold,
  input  logic               statusOk,
  output busCtl_t            ctl,
  output logic               cmdDone
);
  phase_t             phase;
  logic [PHASE_W-1:0] cnt;
  logic               isStat, isRd, nibSel, doneQ;
  logic               lastTick;

  function automatic logic [PHASE_W-1:0] lenM1(input logic [PHASE_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  assign lastTick = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      isStat <= 1'b0;
      isRd   <= 1'b0;
      nibSel <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (cmdStart) begin
            isRd   <= cmdRead;
            isStat <= cfgBusyEn;
            nibSel <= 1'b0;
            phase  <= PH_SETUP;
            cnt    <= lenM1(cfgSetup);
          end
        end
        PH_SETUP: begin
          if (lastTick) begin
            phase <= PH_PULSE;
            cnt   <= lenM1(cfgPulse);
          end else cnt <= cnt - 1'b1;
        end
        PH_PULSE: begin
          if (lastTick) begin
            phase <= PH_HOLD;
            cnt   <= lenM1(cfgHold);
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (!lastTick) cnt <= cnt - 1'b1;
          else if (isStat) begin
            if (statusOk) isStat <= 1'b0;
            phase <= PH_SETUP;
            cnt   <= lenM1(cfgSetup);
          end else if (cfgNibble && !nibSel) begin
            nibSel <= 1'b1;
            phase  <= PH_SETUP;
            cnt    <= lenM1(cfgSetup);
          end else begin
            phase <= PH_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.active    = (phase != PH_IDLE);
    ctl.isStatus  = ctl.active & isStat;
    ctl.isRead    = ctl.active & (isStat | isRd);
    ctl.strobeOn  = (phase == PH_PULSE);
    ctl.sampleNow = (phase == PH_PULSE) & lastTick;
    ctl.nibSel    = nibSel;
    ctl.loadCmd   = (phase == PH_IDLE) & cmdStart;
  end

  assign cmdDone = doneQ;
endmodule

// File: rtl/lcdseq_dp.sv
module lcdseq_dp
  import lcdseq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic              cfgMode6800,
  input  logic              cfgNibble,
  input  logic              cfgHighFirst,
  input  logic              cfgCsLow,
  input  logic              cfgStrobeInv,
  input  logic              cfgBusyEn,
  input  logic              cfgBusyLow,
  input  logic [$clog2(DATA_W)-1:0] cfgBusyIdx,
  input  logic              cfgStatusRsHigh,
  input  logic [DATA_W-1:0] cmdWdata,
  input  logic              cmdRs,
  input  logic [DATA_W-1:0] lcdDin,
  output logic [DATA_W-1:0] cmdRdata,
  output logic              statusOk,
  output logic [DATA_W-1:0] lcdDout,
  output logic              lcdOe,
  output logic              lcdRs,
  output logic              lcdCs,
  output logic              lcdEr,
  output logic              lcdRw
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              rsQ, okQ;
  logic              upperSlot;
  logic [HALF-1:0]   outNib;

  // first nibble lands in the upper half when high-first, second otherwise
  assign upperSlot = ctl.nibSel ^ cfgHighFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdataQ <= '0;
      rdataQ <= '0;
      rsQ    <= 1'b0;
      okQ    <= 1'b0;
    end else begin
      if (ctl.loadCmd) begin
        wdataQ <= cmdWdata;
        rsQ    <= cmdRs;
      end
      if (ctl.sampleNow) begin
        if (ctl.isStatus) okQ <= (lcdDin[cfgBusyIdx] != cfgBusyLow);
        else if (ctl.isRead) begin
          if (!cfgNibble) rdataQ <= lcdDin;
          else if (upperSlot) rdataQ[DATA_W-1:HALF] <= lcdDin[DATA_W-1:HALF];
          else rdataQ[HALF-1:0] <= lcdDin[DATA_W-1:HALF];
        end
      end
    end
  end

  assign outNib = upperSlot ? wdataQ[DATA_W-1:HALF] : wdataQ[HALF-1:0];

  always_comb begin
    if (!ctl.active || ctl.isRead) lcdDout = '0;
    else if (cfgNibble)            lcdDout = {outNib, {HALF{1'b0}}};
    else                           lcdDout = wdataQ;
  end

  assign lcdOe = ctl.active & ~ctl.isRead;
  assign lcdCs = ctl.active ^ cfgCsLow;

  always_comb begin
    if (!ctl.active)       lcdRs = 1'b0;
    else if (ctl.isStatus) lcdRs = cfgStatusRsHigh;
    else if (cfgBusyEn)    lcdRs = ~cfgStatusRsHigh;
    else                   lcdRs = rsQ;
  end

  always_comb begin
    if (cfgMode6800) begin
      lcdEr = ctl.strobeOn ^ cfgStrobeInv;
      lcdRw = ctl.active ? ctl.isRead : 1'b1;
    end else begin
      lcdEr = ~(ctl.strobeOn & ctl.isRead) ^ cfgStrobeInv;
      lcdRw = ~(ctl.strobeOn & ctl.active & ~ctl.isRead);
    end
  end

  assign cmdRdata = rdataQ;
  assign statusOk = okQ;
endmodule

// File: rtl/lcd_par_seq.sv
module lcd_par_seq
  import lcdseq_pkg::*;
#(
  parameter int PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgMode6800,
  input  logic               cfgNibble,
  input  logic               cfgHighFirst,
  input  logic               cfgCsLow,
  input  logic               cfgStrobeInv,
  input  logic               cfgBusyEn,
  input  logic               cfgBusyLow,
  input  logic [2:0]         cfgBusyIdx,
  input  logic               cfgStatusRsHigh,
  input  logic [PHASE_W-1:0] cfgSetup,
  input  logic [PHASE_W-1:0] cfgPulse,
  input  logic [PHASE_W-1:0] cfgHold,
  input  logic               cmdStart,
  input  logic               cmdRead,
  input  logic               cmdRs,
  input  logic [7:0]         cmdWdata,
  output logic               cmdDone,
  output logic [7:0]         cmdRdata,
  output logic [7:0]         lcdDout,
  input  logic [7:0]         lcdDin,
  output logic               lcdOe,
  output logic               lcdRs,
  output logic               lcdCs,
  output logic               lcdEr,
  output logic               lcdRw
);
  busCtl_t ctl;
  logic    statusOk;

  lcdseq_ctrl #(.PHASE_W(PHASE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cfgBusyEn(cfgBusyEn), .cfgNibble(cfgNibble), .cfgSetup(cfgSetup),
    .cfgPulse(cfgPulse), .cfgHold(cfgHold), .statusOk(statusOk),
    .ctl(ctl), .cmdDone(cmdDone)
  );

  lcdseq_dp #(.DATA_W(8)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cfgMode6800(cfgMode6800),
    .cfgNibble(cfgNibble), .cfgHighFirst(cfgHighFirst), .cfgCsLow(cfgCsLow),
    .cfgStrobeInv(cfgStrobeInv), .cfgBusyEn(cfgBusyEn), .cfgBusyLow(cfgBusyLow),
    .cfgBusyIdx(cfgBusyIdx), .cfgStatusRsHigh(cfgStatusRsHigh),
    .cmdWdata(cmdWdata), .cmdRs(cmdRs), .lcdDin(lcdDin), .cmdRdata(cmdRdata),
    .statusOk(statusOk), .lcdDout(lcdDout), .lcdOe(lcdOe), .lcdRs(lcdRs),
    .lcdCs(lcdCs), .lcdEr(lcdEr), .lcdRw(lcdRw)
  );
endmodule

// File: rtl/lcdseq_chk.sv
module lcdseq_chk (
  input logic clk,
  input logic rstN,
  input logic cfgMode6800,
  input logic cfgCsLow,
  input logic cfgStrobeInv,
  input logic cmdDone,
  input logic lcdOe,
  input logic lcdCs,
  input logic lcdEr,
  input logic lcdRw
);
  logic csOn, erLevel, rdAct, wrAct, anyStrobe;
  assign csOn      = lcdCs ^ cfgCsLow;
  assign erLevel   = lcdEr ^ cfgStrobeInv;
  assign rdAct     = ~cfgMode6800 & ~erLevel;
  assign wrAct     = ~cfgMode6800 & ~lcdRw;
  assign anyStrobe = cfgMode6800 ? erLevel : (rdAct | wrAct);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |=> !cmdDone);
  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> (!csOn && !lcdOe && !anyStrobe));
  // R11
  oe_write6800_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode6800 && lcdOe) |-> !lcdRw);
  // R11
  oe_noread8080_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgMode6800 && lcdOe) |-> !rdAct);
  // R1
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdAct && wrAct));
  // R4
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyStrobe |-> csOn);
  // R9
  setup_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyStrobe) |-> $past(csOn));
endmodule

bind lcd_par_seq lcdseq_chk u_chk (
  .clk(clk), .rstN(rstN), .cfgMode6800(cfgMode6800), .cfgCsLow(cfgCsLow),
  .cfgStrobeInv(cfgStrobeInv), .cmdDone(cmdDone), .lcdOe(lcdOe),
  .lcdCs(lcdCs), .lcdEr(lcdEr), .lcdRw(lcdRw)
);

// File: tb/sim_lcd_par_seq.sv
`timescale 1ns/1ps
module sim_lcd_par_seq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMode6800 = 0, cfgNibble = 0, cfgHighFirst = 0, cfgCsLow = 0;
  logic cfgStrobeInv = 0, cfgBusyEn = 0, cfgBusyLow = 0, cfgStatusRsHigh = 0;
  logic [2:0] cfgBusyIdx = 3'd7;
  logic [3:0] cfgSetup = 4'd1, cfgPulse = 4'd1, cfgHold = 4'd1;
  logic cmdStart = 0, cmdRead = 0, cmdRs = 0;
  logic [7:0] cmdWdata = 8'h00;
  logic cmdDone;
  logic [7:0] cmdRdata, lcdDout;
  logic [7:0] lcdDin = 8'h00;
  logic lcdOe, lcdRs, lcdCs, lcdEr, lcdRw;

  always #4 clk = ~clk;

  lcd_par_seq #(.PHASE_W(4)) u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  int doneSeen = 0, statSeen = 0, busyN = 0;
  logic [7:0] rdA = 8'h00, rdB = 8'h00;
  bit strobePrev = 0;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: queue of pending accesses (0 status, 1 first data, 2 second nibble)
  int q[$];
  int mPhase = 0, mLeft = 0, mStatCnt = 0;
  bit mIsRead = 0, mRs = 0, mOk = 0, mDone = 0;
  logic [7:0] mW = 0, mRd = 0;

  function automatic int plen(input logic [3:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    mDone = 0;
    if (!rstN) begin
      mPhase = 0; q.delete(); mRd = 0;
    end else if (mPhase == 0) begin
      if (cmdStart) begin
        q.delete();
        if (cfgBusyEn) q.push_back(0);
        q.push_back(1);
        if (cfgNibble) q.push_back(2);
        mIsRead = cmdRead; mW = cmdWdata; mRs = cmdRs; mStatCnt = 0;
        mPhase = 1; mLeft = plen(cfgSetup);
      end
    end else if (mLeft > 1) mLeft--;
    else begin
      case (mPhase)
        1: begin mPhase = 2; mLeft = plen(cfgPulse); end
        2: begin
          if (q[0] == 0) begin
            mOk = (lcdDin[cfgBusyIdx] == !cfgBusyLow);
            mStatCnt++;
          end else if (mIsRead) begin
            if (!cfgNibble) mRd = lcdDin;
            else if ((q[0] == 1) == cfgHighFirst) mRd[7:4] = lcdDin[7:4];
            else mRd[3:0] = lcdDin[7:4];
          end
          mPhase = 3; mLeft = plen(cfgHold);
        end
        default: begin
          int cur;
          cur = q.pop_front();
          if (cur == 0 && !mOk) q.push_front(0);
          if (q.size() == 0) begin mPhase = 0; mDone = 1; end
          else begin mPhase = 1; mLeft = plen(cfgSetup); end
        end
      endcase
    end
  end

  // compare pins with the model; drive the display model's data
  always @(negedge clk) begin
    bit act, st, rd, strb, sNow;
    logic [7:0] eDout, w, b;
    logic eRs, eEr, eRw;
    act  = (mPhase != 0);
    st   = act && q.size() > 0 && q[0] == 0;
    rd   = act && (st || mIsRead);
    strb = (mPhase == 2);
    eRs  = !act ? 1'b0 : st ? cfgStatusRsHigh : (cfgBusyEn ? !cfgStatusRsHigh : mRs);
    if (cfgMode6800) begin
      eEr = strb ^ cfgStrobeInv;
      eRw = act ? rd : 1'b1;
    end else begin
      eEr = (strb && rd) ? cfgStrobeInv : !cfgStrobeInv;
      eRw = (strb && !rd) ? 1'b0 : 1'b1;
    end
    w = mW;
    if (!act || rd) eDout = 8'h00;
    else if (!cfgNibble) eDout = w;
    else if ((q[0] == 1) == cfgHighFirst) eDout = {w[7:4], 4'h0};
    else eDout = {w[3:0], 4'h0};
    chk("R4 R13 lcdCs", {7'd0, lcdCs}, {7'd0, act ? !cfgCsLow : cfgCsLow});
    chk("R8 lcdRs", {7'd0, lcdRs}, {7'd0, eRs});
    chk("R1 R5 lcdEr", {7'd0, lcdEr}, {7'd0, eEr});
    chk("R1 lcdRw", {7'd0, lcdRw}, {7'd0, eRw});
    chk("R11 lcdOe", {7'd0, lcdOe}, {7'd0, act && !rd});
    chk("R2 R3 lcdDout", lcdDout, eDout);
    chk("R10 R12 cmdDone", {7'd0, cmdDone}, {7'd0, mDone});
    if (mDone && mIsRead) chk("R10 cmdRdata", cmdRdata, mRd);
    if (cmdDone) doneSeen++;
    sNow = cfgMode6800 ? (lcdEr ^ cfgStrobeInv) : (!(lcdEr ^ cfgStrobeInv) || !lcdRw);
    if (sNow && !strobePrev && cfgBusyEn && lcdRs == cfgStatusRsHigh && lcdCs == !cfgCsLow)
      statSeen++;
    strobePrev = sNow;
    // display model
    if (act && q.size() > 0) begin
      if (q[0] == 0) begin
        b = 8'h5A;
        b[cfgBusyIdx] = (mStatCnt < busyN) ? cfgBusyLow : !cfgBusyLow;
        lcdDin = b;
      end else lcdDin = (q[0] == 1) ? rdA : rdB;
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  function automatic logic [7:0] expRead();
    if (!cfgNibble) return rdA;
    return cfgHighFirst ? {rdA[7:4], rdB[7:4]} : {rdB[7:4], rdA[7:4]};
  endfunction

  task automatic runXfer(input bit rd, input logic [7:0] wd, input bit rs, input int poke,
                         input string tag);
    int d0, s0, n;
    d0 = doneSeen; s0 = statSeen; n = 0;
    @(posedge clk); #1;
    cmdRead = rd; cmdWdata = wd; cmdRs = rs; cmdStart = 1;
    @(posedge clk); #1;
    cmdStart = 0;
    if (poke > 0) begin
      repeat (poke) @(posedge clk);
      #1; cmdStart = 1; cmdRead = !rd; cmdWdata = ~wd;   // R12: must be ignored
      @(posedge clk); #1; cmdStart = 0;
    end
    while (doneSeen == d0 && n < 3000) begin @(posedge clk); n++; end
    repeat (3) @(posedge clk);
    chk({tag, " R10 R12 done count"}, 8'(doneSeen - d0), 8'd1);
    if (rd) chk({tag, " R2 R3 R10 read byte"}, cmdRdata, expRead());
    chk({tag, " R6 R7 status reads"}, 8'(statSeen - s0), cfgBusyEn ? 8'(busyN + 1) : 8'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R13 reset state
    chk("R13 reset lcdCs", {7'd0, lcdCs}, 8'd0);
    chk("R13 reset lcdOe", {7'd0, lcdOe}, 8'd0);
    chk("R13 reset cmdDone", {7'd0, cmdDone}, 8'd0);
    chk("R13 reset lcdEr", {7'd0, lcdEr}, 8'd1);
    rstN = 1;
    // R1 R9 split strobes, byte write, stretched phases
    cfgSetup = 2; cfgPulse = 3; cfgHold = 1;
    runXfer(0, 8'hC3, 1, 0, "t1");
    // R5 R4 split strobes, byte read with inverted strobe and low chip select
    cfgStrobeInv = 1; cfgCsLow = 1; rdA = 8'hA5;
    runXfer(1, 8'h00, 0, 0, "t2");
    // R2 R3 R9 enable style, nibble write, zero phase lengths count as one
    cfgMode6800 = 1; cfgStrobeInv = 0; cfgCsLow = 0; cfgNibble = 1; cfgHighFirst = 1;
    cfgSetup = 0; cfgPulse = 0; cfgHold = 0;
    runXfer(0, 8'h3C, 0, 0, "t3");
    cfgHighFirst = 0;
    runXfer(0, 8'h3C, 1, 0, "t4");
    // R3 nibble read, both orders
    rdA = 8'h7E; rdB = 8'h21;
    runXfer(1, 8'h00, 0, 0, "t5");
    cfgHighFirst = 1;
    runXfer(1, 8'h00, 0, 0, "t6");
    // R6 R7 R8 busy polling, bit 3 waits high, status rs high, byte write
    cfgNibble = 0; cfgBusyEn = 1; cfgBusyIdx = 3; cfgBusyLow = 0; cfgStatusRsHigh = 1;
    cfgSetup = 1; cfgPulse = 2; cfgHold = 2; busyN = 3;
    runXfer(0, 8'h96, 0, 0, "t7");
    // R6 R7 R12 busy bit 7 waits low, split strobes, nibble read, stray start mid-command
    cfgMode6800 = 0; cfgNibble = 1; cfgBusyIdx = 7; cfgBusyLow = 1; cfgStatusRsHigh = 0;
    busyN = 2; rdA = 8'hB0; rdB = 8'h40;
    runXfer(1, 8'h00, 1, 2, "t8");
    // R12 stray start on a plain byte write, ready at once
    cfgBusyEn = 0; cfgNibble = 0; busyN = 0;
    runXfer(0, 8'h5F, 1, 1, "t9");
    // R7 ready immediately with busy on bit 0
    cfgBusyEn = 1; cfgBusyIdx = 0; cfgBusyLow = 0; cfgMode6800 = 1;
    runXfer(1, 8'h00, 0, 0, "t10");
    finishRun();
  end
endmodule